// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Sequencer with Saturation

This block runs a repeated multiply-accumulate loop. It takes two operand pointers, an element count, an element size and a 96-bit accumulator split into three 32-bit words: a low word, a middle word and a high extension word. For each element pair it reads one operand through pointer A and one through pointer B over a single memory read port. Both operands are sign-extended to 32 bits and multiplied. The signed product is added to the 64-bit running sum held in the low and middle words. A carry out of that sum, or a borrow from it, adjusts the signed extension word, so the three words together always hold the exact sum modulo 2^96. When the count reaches zero the block reports a sign flag and an overflow flag. Overflow means the extension word no longer holds a plain sign extension.

The same block also runs the companion saturate operation. In one step it replaces the accumulator with one of two fixed 96-bit patterns, chosen by the flags. A caller loads the operand state with a one-cycle `start` pulse. It then waits for the one-cycle `done` pulse and reads back the updated pointers, count, accumulator words and flags on the output ports, which hold their values until the next accepted start.

Top module: `rmpa_seq`

## Requirements
- R1: A multiply-accumulate start with `in_count` equal to zero issues no memory request. `done` pulses in the cycle after the start edge, and every output equals the matching start input, the flags included.
- R2: A multiply-accumulate start with a non-zero count loads the accumulator words and pointers and clears the overflow flag. `busy` and a clear `out_ovf` are visible in the cycle after the start edge.
- R3: Each pair uses two read handshakes, first at pointer A and then at pointer B. While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_size` stay stable. Read data is right-aligned in `mem_rdata`, and the bits above the element are ignored. `mem_req` is only high while `busy`.
- R4: The size code selects the element: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit (code 3 acts as 32-bit). Each operand is sign-extended from the element's top bit before the multiply.
- R5: After each pair, both pointers advance by the element width in bytes (1, 2 or 4) and the count drops by exactly one. The loop ends when the count reaches zero.
- R6: At the end of the loop, {`out_acc_hi`, `out_acc_mid`, `out_acc_lo`} equals the start accumulator, read as a signed 96-bit value, plus the sum of all products, modulo 2^96. A non-negative product that wraps the 64-bit sum increments the extension word. A negative product that borrows from it decrements the extension word.
- R7: `done` pulses one cycle after the final accumulate. At that point `out_sign` equals bit 31 of `out_acc_hi`, and `out_ovf` is set exactly when `out_acc_hi` is neither 0x00000000 nor 0xFFFFFFFF. `done` is never high while `busy`.
- R8: A saturate start with `in_ovf` set and `in_sign` set loads hi/mid/lo = 0x00000000/0x7FFFFFFF/0xFFFFFFFF. With `in_ovf` set and `in_sign` clear it loads 0xFFFFFFFF/0x80000000/0x00000000. With `in_ovf` clear the words pass through unchanged. In all three cases the flags equal the inputs, no memory request is made, and `done` pulses in the cycle after the start edge.
- R9: A `start` pulse while `busy` is ignored: the running loop finishes with the result it would have had without the pulse.
- R10: After reset the block is idle. `done` and `mem_req` are low, and every output word and flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_sat | input | 1 | 1 = saturate operation, 0 = multiply-accumulate loop |
| elem_size | input | 2 | Element size code (0 byte, 1 half, 2 word) |
| in_src_a | input | ADDR_W | Start value of pointer A |
| in_src_b | input | ADDR_W | Start value of pointer B |
| in_count | input | CNT_W | Number of element pairs |
| in_acc_lo | input | 32 | Start accumulator low word |
| in_acc_mid | input | 32 | Start accumulator middle word |
| in_acc_hi | input | 32 | Start accumulator extension word |
| in_sign | input | 1 | Start sign flag |
| in_ovf | input | 1 | Start overflow flag |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_size | output | 2 | Read element size code |
| mem_ready | input | 1 | Read accepted; `mem_rdata` valid in the same cycle |
| mem_rdata | input | 32 | Read data, element in the low bits |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| out_src_a | output | ADDR_W | Current pointer A |
| out_src_b | output | ADDR_W | Current pointer B |
| out_count | output | CNT_W | Current remaining count |
| out_acc_lo | output | 32 | Accumulator low word |
| out_acc_mid | output | 32 | Accumulator middle word |
| out_acc_hi | output | 32 | Accumulator extension word |
| out_sign | output | 1 | Sign flag |
| out_ovf | output | 1 | Overflow flag |

## Verification
Saturate and zero-count starts finish on the start edge. Their results and the `done` pulse are read in the very next cycle, without waiting. For a loop, only `busy` and the cleared overflow flag are due in the cycle after the start edge, and the bench checks them there. The final words, pointers and flags are due on the `done` pulse, which comes two edges after the handshake that delivers the last B operand. The bench polls `done` at each falling edge and compares everything at that sample. It counts handshakes on its own memory model, whose response latency is changed per test, so the fetch order and the stable request are covered under stalls as well.

// File: rtl/rmpa_pkg.sv
package rmpa_pkg;

    localparam int WORD_W = 32;
    localparam int SUM_W  = 2 * WORD_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } elem_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_ACCUM
    } seq_state_e;

    // Extension word above a 64-bit unsigned running sum.
    typedef struct packed {
        logic [WORD_W-1:0] ext;
        logic [SUM_W-1:0]  sum;
    } wide_acc_t;

    function automatic logic [WORD_W-1:0] sext_elem(input logic [WORD_W-1:0] raw,
                                                    input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return {{(WORD_W-8){raw[7]}}, raw[7:0]};
            SZ_HALF: return {{(WORD_W-16){raw[15]}}, raw[15:0]};
            default: return raw;
        endcase
    endfunction

    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic ext_overflow(input logic [WORD_W-1:0] ext);
        return !((ext == '0) || (ext == '1));
    endfunction

    function automatic wide_acc_t sat_pattern(input logic neg);
        wide_acc_t r;
        if (neg) begin
            r.ext = '0;
            r.sum = {1'b0, {(SUM_W-1){1'b1}}};
        end else begin
            r.ext = '1;
            r.sum = {1'b1, {(SUM_W-1){1'b0}}};
        end
        return r;
    endfunction

endpackage

// File: rtl/rmpa_mac_step.sv
module rmpa_mac_step
    import rmpa_pkg::*;
(
    input  wide_acc_t         acc_in,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output wide_acc_t         acc_out
);
    logic [SUM_W-1:0] a_wide;
    logic [SUM_W-1:0] b_wide;
    logic [SUM_W-1:0] product;
    logic [SUM_W-1:0] sum_next;
    logic             prod_neg;

    // Low half of the product is independent of operand signedness.
    assign a_wide   = {{WORD_W{op_a[WORD_W-1]}}, op_a};
    assign b_wide   = {{WORD_W{op_b[WORD_W-1]}}, op_b};
    assign product  = a_wide * b_wide;
    assign prod_neg = product[SUM_W-1];
    assign sum_next = acc_in.sum + product;

    always_comb begin
        acc_out.sum = sum_next;
        acc_out.ext = acc_in.ext;
        if (prod_neg && (sum_next > acc_in.sum)) begin
            acc_out.ext = acc_in.ext - WORD_W'(1);
        end else if (!prod_neg && (sum_next < acc_in.sum)) begin
            acc_out.ext = acc_in.ext + WORD_W'(1);
        end
    end
endmodule

// File: rtl/rmpa_clamp.sv
module rmpa_clamp
    import rmpa_pkg::*;
(
    input  wide_acc_t acc_in,
    input  logic      ovf,
    input  logic      neg,
    output wide_acc_t acc_out
);
    always_comb begin
        if (ovf) begin
            acc_out = sat_pattern(neg);
        end else begin
            acc_out = acc_in;
        end
    end
endmodule

// File: rtl/rmpa_seq.sv
module rmpa_seq
    import rmpa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_sat,
    input  logic [1:0]        elem_size,
    input  logic [ADDR_W-1:0] in_src_a,
    input  logic [ADDR_W-1:0] in_src_b,
    input  logic [CNT_W-1:0]  in_count,
    input  logic [WORD_W-1:0] in_acc_lo,
    input  logic [WORD_W-1:0] in_acc_mid,
    input  logic [WORD_W-1:0] in_acc_hi,
    input  logic              in_sign,
    input  logic              in_ovf,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] out_src_a,
    output logic [ADDR_W-1:0] out_src_b,
    output logic [CNT_W-1:0]  out_count,
    output logic [WORD_W-1:0] out_acc_lo,
    output logic [WORD_W-1:0] out_acc_mid,
    output logic [WORD_W-1:0] out_acc_hi,
    output logic              out_sign,
    output logic              out_ovf
);
    seq_state_e        state_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] ptr_a_q;
    logic [ADDR_W-1:0] ptr_b_q;
    logic [CNT_W-1:0]  cnt_q;
    wide_acc_t         acc_q;
    logic              sign_q;
    logic              ovf_q;
    logic              done_q;
    logic [WORD_W-1:0] opa_q;
    logic [WORD_W-1:0] opb_q;

    wide_acc_t         acc_start;
    wide_acc_t         acc_stepped;
    wide_acc_t         acc_clamped;
    logic [ADDR_W-1:0] ptr_step;
    logic              last_pair;

    assign acc_start = '{ext: in_acc_hi, sum: {in_acc_mid, in_acc_lo}};
    assign ptr_step  = ADDR_W'(elem_bytes(size_q));
    assign last_pair = (cnt_q == CNT_W'(1));

    rmpa_mac_step u_step (
        .acc_in  (acc_q),
        .op_a    (opa_q),
        .op_b    (opb_q),
        .acc_out (acc_stepped)
    );

    rmpa_clamp u_clamp (
        .acc_in  (acc_start),
        .ovf     (in_ovf),
        .neg     (in_sign),
        .acc_out (acc_clamped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            size_q  <= '0;
            ptr_a_q <= '0;
            ptr_b_q <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
            sign_q  <= 1'b0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
            opa_q   <= '0;
            opb_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        size_q  <= elem_size;
                        ptr_a_q <= in_src_a;
                        ptr_b_q <= in_src_b;
                        cnt_q   <= in_count;
                        sign_q  <= in_sign;
                        ovf_q   <= in_ovf;
                        if (op_sat) begin
                            acc_q  <= acc_clamped;
                            done_q <= 1'b1;
                        end else if (in_count == '0) begin
                            acc_q  <= acc_start;
                            done_q <= 1'b1;
                        end else begin
                            acc_q   <= acc_start;
                            ovf_q   <= 1'b0;
                            state_q <= ST_FETCH_A;
                        end
                    end
                end
                ST_FETCH_A: begin
                    if (mem_ready) begin
                        opa_q   <= sext_elem(mem_rdata, size_q);
                        state_q <= ST_FETCH_B;
                    end
                end
                ST_FETCH_B: begin
                    if (mem_ready) begin
                        opb_q   <= sext_elem(mem_rdata, size_q);
                        state_q <= ST_ACCUM;
                    end
                end
                ST_ACCUM: begin
                    acc_q   <= acc_stepped;
                    ptr_a_q <= ptr_a_q + ptr_step;
                    ptr_b_q <= ptr_b_q + ptr_step;
                    cnt_q   <= cnt_q - CNT_W'(1);
                    if (last_pair) begin
                        sign_q  <= acc_stepped.ext[WORD_W-1];
                        ovf_q   <= ext_overflow(acc_stepped.ext);
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FETCH_A;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req     = (state_q == ST_FETCH_A) || (state_q == ST_FETCH_B);
    assign mem_addr    = (state_q == ST_FETCH_B) ? ptr_b_q : ptr_a_q;
    assign mem_size    = size_q;
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign out_src_a   = ptr_a_q;
    assign out_src_b   = ptr_b_q;
    assign out_count   = cnt_q;
    assign out_acc_lo  = acc_q.sum[WORD_W-1:0];
    assign out_acc_mid = acc_q.sum[SUM_W-1:WORD_W];
    assign out_acc_hi  = acc_q.ext;
    assign out_sign    = sign_q;
    assign out_ovf     = ovf_q;
endmodule

// File: rtl/rmpa_seq_chk.sv
module rmpa_seq_chk
    import rmpa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              op_sat,
    input logic [CNT_W-1:0]  in_count,
    input logic [WORD_W-1:0] in_acc_lo,
    input logic [WORD_W-1:0] in_acc_mid,
    input logic [WORD_W-1:0] in_acc_hi,
    input logic              in_sign,
    input logic              in_ovf,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic              mem_ready,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  out_count,
    input logic [WORD_W-1:0] out_acc_lo,
    input logic [WORD_W-1:0] out_acc_mid,
    input logic [WORD_W-1:0] out_acc_hi,
    input logic              out_sign,
    input logic              out_ovf
);
    p_zero_count_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op_sat && (in_count == '0)) |=>
            (done && !busy && !mem_req && out_ovf == $past(in_ovf) && out_sign == $past(in_sign)
             && out_acc_hi == $past(in_acc_hi) && out_acc_mid == $past(in_acc_mid)
             && out_acc_lo == $past(in_acc_lo)));

    p_ovf_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op_sat && (in_count != '0)) |=>
            (busy && !out_ovf && out_count == $past(in_count)));

    p_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (out_count != $past(out_count))) |->
            (out_count == $past(out_count) - CNT_W'(1)));

    p_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |->
            (out_sign == out_acc_hi[WORD_W-1]
             && out_ovf == !((out_acc_hi == '0) || (out_acc_hi == '1))
             && out_count == '0));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op_sat && in_ovf) |=>
            (done && out_ovf && out_sign == $past(in_sign)
             && out_acc_hi == ($past(in_sign) ? 32'h0000_0000 : 32'hFFFF_FFFF)
             && out_acc_mid == ($past(in_sign) ? 32'h7FFF_FFFF : 32'h8000_0000)
             && out_acc_lo == ($past(in_sign) ? 32'hFFFF_FFFF : 32'h0000_0000)));
endmodule

bind rmpa_seq rmpa_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rmpa_seq.sv
module tb_rmpa_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_sat = 1'b0;
    logic [1:0]  elem_size = 2'd0;
    logic [31:0] in_src_a = '0, in_src_b = '0, in_count = '0;
    logic [31:0] in_acc_lo = '0, in_acc_mid = '0, in_acc_hi = '0;
    logic        in_sign = 1'b0, in_ovf = 1'b0;
    logic        mem_req, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [1:0]  mem_size;
    logic        busy, done, out_sign, out_ovf;
    logic [31:0] out_src_a, out_src_b, out_count, out_acc_lo, out_acc_mid, out_acc_hi;

    int checks = 0;
    int failures = 0;
    int lat_cfg = 0;
    int wait_cnt = 0;
    int hs_cnt = 0;
    int req_cycles = 0;
    logic [31:0] first_addr = '0;
    logic [7:0] mem [0:4095];

    always #2 clk = ~clk;

    rmpa_seq dut (.*);

    function automatic logic [31:0] rd_raw(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = mem[(a + i) & 32'hFFF];
        if (sz == 2'd0) w[31:8] = 24'hA55A5A;
        else if (sz == 2'd1) w[31:16] = 16'h5AA5;
        return w;
    endfunction

    function automatic logic signed [31:0] ld_s(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = mem[(a + i) & 32'hFFF];
        if (sz == 2'd0) return $signed({{24{w[7]}}, w[7:0]});
        if (sz == 2'd1) return $signed({{16{w[15]}}, w[15:0]});
        return $signed(w);
    endfunction

    // Memory model: answers after lat_cfg waiting cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat_cfg) begin
                mem_ready = 1'b1;
                mem_rdata = rd_raw(mem_addr, mem_size);
                wait_cnt  = 0;
            end else begin
                mem_ready = 1'b0;
                wait_cnt  = wait_cnt + 1;
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end
    end

    always @(posedge clk) begin
        if (mem_req) req_cycles <= req_cycles + 1;
        if (mem_req && mem_ready) begin
            if (hs_cnt == 0) first_addr <= mem_addr;
            hs_cnt <= hs_cnt + 1;
        end
    end

    task automatic chk(input string rq, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [1:0] sz, input logic [31:0] v);
        int nb;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int i = 0; i < nb; i++) mem[(a + i) & 12'hFFF] = v[i*8 +: 8];
    endtask

    task automatic wait_done(input string rq);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(rq, "done pulse arrives", {127'd0, seen}, 128'd1);
    endtask

    task automatic t_reset();
        chk("R10", "busy after reset", {127'd0, busy}, 0);
        chk("R10", "done after reset", {127'd0, done}, 0);
        chk("R10", "mem_req after reset", {127'd0, mem_req}, 0);
        chk("R10", "acc words after reset", {32'd0, out_acc_hi, out_acc_mid, out_acc_lo}, 0);
        chk("R10", "pointers/count after reset", {32'd0, out_src_a, out_src_b, out_count}, 0);
        chk("R10", "flags after reset", {126'd0, out_sign, out_ovf}, 0);
    endtask

    task automatic t_zero_count();
        int r0;
        r0 = req_cycles;
        start = 1'b1; op_sat = 1'b0; elem_size = 2'd1; in_count = 0;
        in_src_a = 32'h120; in_src_b = 32'h340;
        in_acc_hi = 32'h8000_0001; in_acc_mid = 32'h1234_5678; in_acc_lo = 32'h9ABC_DEF0;
        in_sign = 1'b1; in_ovf = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1", "done one cycle after start", {126'd0, done, busy}, 128'd2);
        chk("R1", "accumulator unchanged", {32'd0, out_acc_hi, out_acc_mid, out_acc_lo},
            {32'd0, 32'h8000_0001, 32'h1234_5678, 32'h9ABC_DEF0});
        chk("R1", "flags unchanged", {126'd0, out_sign, out_ovf}, 128'd3);
        chk("R1", "pointers and count unchanged", {32'd0, out_src_a, out_src_b, out_count},
            {32'd0, 32'h120, 32'h340, 32'd0});
        @(negedge clk);
        chk("R1", "no memory request", req_cycles - r0, 0);
    endtask

    task automatic do_mac(input string nm, input logic [1:0] sz, input int n,
                          input logic [31:0] pa, input logic [31:0] pb,
                          input logic [31:0] h6, input logic [31:0] h5, input logic [31:0] h4,
                          input int lat, input bit poke);
        logic signed [127:0] ref_v, aw, bw;
        logic [31:0] e6;
        int step, hs0;
        step  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        ref_v = $signed({{32{h6[31]}}, h6, h5, h4});
        for (int i = 0; i < n; i++) begin
            aw = ld_s(pa + i * step, sz);
            bw = ld_s(pb + i * step, sz);
            ref_v = ref_v + aw * bw;
        end
        e6 = ref_v[95:64];
        lat_cfg = lat;
        hs0 = hs_cnt;
        start = 1'b1; op_sat = 1'b0; elem_size = sz; in_count = n;
        in_src_a = pa; in_src_b = pb;
        in_acc_hi = h6; in_acc_mid = h5; in_acc_lo = h4;
        in_sign = 1'b1; in_ovf = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", {nm, " busy with overflow cleared"}, {126'd0, busy, out_ovf}, 128'd2);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; op_sat = 1'b1; in_count = 0;
            in_acc_hi = 32'h1111_1111; in_acc_mid = 32'h2222_2222; in_acc_lo = 32'h3333_3333;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done("R7");
        chk(poke ? "R9" : "R6", {nm, " accumulator"}, {32'd0, out_acc_hi, out_acc_mid, out_acc_lo},
            {32'd0, ref_v[95:0]});
        chk("R5", {nm, " pointer A"}, out_src_a, pa + n * step);
        chk("R5", {nm, " pointer B"}, out_src_b, pb + n * step);
        chk("R5", {nm, " count"}, out_count, 0);
        chk("R7", {nm, " sign flag"}, {127'd0, out_sign}, {127'd0, e6[31]});
        chk("R7", {nm, " overflow flag"}, {127'd0, out_ovf},
            {127'd0, !(e6 == 32'h0 || e6 == 32'hFFFF_FFFF)});
        chk("R3", {nm, " handshakes"}, hs_cnt - hs0, 2 * n);
        if (hs0 == 0) chk("R3", {nm, " first read at pointer A"}, first_addr, pa);
        @(negedge clk);
        chk("R7", {nm, " done is one cycle"}, {127'd0, done}, 0);
    endtask

    task automatic do_sat(input string nm, input logic ov, input logic sg,
                          input logic [31:0] h6, input logic [31:0] h5, input logic [31:0] h4);
        logic [95:0] ex;
        int r0;
        if (!ov) ex = {h6, h5, h4};
        else if (sg) ex = {32'h0, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
        else ex = {32'hFFFF_FFFF, 32'h8000_0000, 32'h0};
        r0 = req_cycles;
        start = 1'b1; op_sat = 1'b1; in_count = 5; in_ovf = ov; in_sign = sg;
        in_acc_hi = h6; in_acc_mid = h5; in_acc_lo = h4;
        @(negedge clk);
        start = 1'b0; op_sat = 1'b0;
        chk("R8", {nm, " done, not busy"}, {126'd0, done, busy}, 128'd2);
        chk("R8", {nm, " accumulator"}, {32'd0, out_acc_hi, out_acc_mid, out_acc_lo}, {32'd0, ex});
        chk("R8", {nm, " flags kept"}, {126'd0, out_sign, out_ovf}, {126'd0, sg, ov});
        @(negedge clk);
        chk("R8", {nm, " no memory request"}, req_cycles - r0, 0);
    endtask

    task automatic run_all();
        logic [31:0] s6, s5, s4;
        logic so, ss;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_count();
        // R4: signed bytes with garbage above the element
        for (int i = 0; i < 40; i++) put(32'h000 + i, 2'd0, $urandom);
        for (int i = 0; i < 40; i++) put(32'h080 + i, 2'd0, $urandom);
        do_mac("bytes R4", 2'd0, 20, 32'h000, 32'h080, 32'h0, 32'h0, 32'h5, 0, 1'b0);
        for (int i = 0; i < 16; i++) put(32'h100 + 2 * i, 2'd1, $urandom);
        for (int i = 0; i < 16; i++) put(32'h180 + 2 * i, 2'd1, $urandom);
        do_mac("halves R4", 2'd1, 16, 32'h100, 32'h180, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 2, 1'b0);
        for (int i = 0; i < 12; i++) put(32'h200 + 4 * i, 2'd2, $urandom);
        for (int i = 0; i < 12; i++) put(32'h280 + 4 * i, 2'd2, $urandom);
        do_mac("words", 2'd2, 12, 32'h200, 32'h280, 32'h0, 32'hFFFF_FFF0, 32'h0, 1, 1'b1);
        // large positive products drive the extension word to 2
        for (int i = 0; i < 8; i++) begin
            put(32'h300 + 4 * i, 2'd2, 32'h8000_0000);
            put(32'h340 + 4 * i, 2'd2, 32'h8000_0000);
        end
        do_mac("big products R6", 2'd2, 8, 32'h300, 32'h340, 32'h0, 32'h0, 32'h0, 3, 1'b0);
        // carry into extension: 1*1 on a full 64-bit sum
        put(32'h400, 2'd2, 32'h1);
        put(32'h404, 2'd2, 32'h1);
        do_mac("carry", 2'd2, 1, 32'h400, 32'h404, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0);
        chk("R6", "carry sets extension to 1", out_acc_hi, 32'h1);
        s6 = out_acc_hi; s5 = out_acc_mid; s4 = out_acc_lo; so = out_ovf; ss = out_sign;
        do_sat("positive clamp", so, ss, s6, s5, s4);
        // borrow: 1 * -1 (halves) from zero
        put(32'h410, 2'd1, 32'h0001);
        put(32'h420, 2'd1, 32'hFFFF);
        do_mac("borrow", 2'd1, 1, 32'h410, 32'h420, 32'h0, 32'h0, 32'h0, 1, 1'b0);
        chk("R6", "borrow gives all-ones", {32'd0, out_acc_hi, out_acc_mid, out_acc_lo},
            {32'd0, {96{1'b1}}});
        chk("R7", "borrow: sign set, no overflow", {126'd0, out_sign, out_ovf}, 128'd2);
        // negative overflow, then clamp
        do_mac("neg overflow", 2'd2, 1, 32'h400, 32'h404, 32'h8000_0000, 32'hFFFF_FFFF,
               32'hFFFF_FFFF, 2, 1'b0);
        chk("R7", "negative overflow flags", {126'd0, out_sign, out_ovf}, 128'd3);
        s6 = out_acc_hi; s5 = out_acc_mid; s4 = out_acc_lo; so = out_ovf; ss = out_sign;
        do_sat("negative clamp", so, ss, s6, s5, s4);
        do_sat("no overflow", 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h1234_4321);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=expired expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule